// File: doc/BRIEF.md
# I2C Register Target with Device and Group Addressing

This block is the serial front end of a register bank. It watches SCL and SDA, recognises START, repeated START and STOP, and answers address bytes by pulling SDA low through an open-drain enable. After a successful write address, the first byte sets an 8-bit register pointer. Each following byte is written at the pointer, and the pointer then steps by one. A read returns bytes from the pointer with the same step. It continues while the controller acknowledges and ends on a not-acknowledge.

Until its addresses are locked, the target answers only the fixed start-up address 0x0D. Three registers held inside the block carry a programmable device address, a programmable group address and a lock bit. Once locked, the device address serves reads and writes, and the group address serves writes only. The wider register file sits outside the block and is reached through a write strobe port and a combinational read port. A two-bit grant input decides whether the configuration area (0x03 to 0x25) and the status area (0x26 to 0x37) accept writes. SCL and SDA are oversampled in the system clock domain.

The control state machine has these states. IDLE waits for START. ADDR shifts in the address byte. ADDR_DONE holds the decision until SCL falls and leads to ADDR_ACK on a hit or SKIP on a miss. ADDR_ACK goes to RD for a read or REG for a write. REG shifts in the pointer byte, and REG_DONE then REG_ACK acknowledge it before WR. WR shifts a data byte. WR_DONE goes to WR_ACK when the byte is accepted and to SKIP when it is refused. WR_ACK returns to WR. RD shifts a byte out, and RD_ACK samples the controller's answer. An acknowledge leads through RD_NEXT back to RD, and a not-acknowledge leads to SKIP. SKIP waits with SDA released. From any state, STOP leads to IDLE and START leads to ADDR.

Top module: `i2c_reg_target`

## Requirements
- R1: Bytes are shifted MSB first. SDA is never driven from reset, and it is released in the cycle that follows a detected STOP.
- R2: While the lock bit is 0, only the 7-bit address 0x0D is acknowledged (for reads and writes), and any other address is answered with not-acknowledge.
- R3: While the lock bit is 1, the device address is acknowledged for reads and writes, and 0x0D is no longer answered unless it equals a programmed address.
- R4: While locked, a write addressed to the group address is acknowledged and performed, and a read addressed to the group address is not acknowledged.
- R5: The first byte after a write address is always acknowledged and loads the pointer. Each acknowledged data byte is written at the pointer, and the pointer then increments by 1.
- R6: A read that follows no pointer byte since the last STOP begins at register 0x26. A repeated START keeps the pointer set earlier in the same transfer.
- R7: During a read, a controller acknowledge returns the byte at the next pointer, and a not-acknowledge ends the read with SDA released.
- R8: Register 0x00 holds the device address in bits 6:0 and register 0x01 the group address in bits 6:0. They accept writes only while the lock bit is 0. A refused write is not acknowledged and leaves the value unchanged.
- R9: The lock bit is bit 0 of register 0x02. A byte with bit 0 set is refused (not acknowledged, lock stays 0) unless the addresses are valid. Valid means that neither address is 0x0D or 0x00 and that the two differ.
- R10: A byte at 0x03 to 0x25 is written to the register file and acknowledged only while area_grant[0] is 1. A byte at 0x26 to 0x37 is handled the same way only while area_grant[1] is 1. Otherwise the byte is not acknowledged and no write occurs.
- R11: Registers 0x38 to 0xFF read as 0x00 and refuse writes. Bits 7 of 0x00 and 0x01 and bits 7:1 of 0x02 read as 0.
- R12: After reset, the device and group addresses are 0x00 and the lock bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock level seen on the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_oe | output | 1 | When 1, the open-drain driver pulls SDA low |
| area_grant | input | 2 | Bit 0 allows configuration-area writes, bit 1 allows status-area writes |
| rf_wr_en | output | 1 | One-cycle write strobe to the register file |
| rf_wr_addr | output | 8 | Register address of the strobe |
| rf_wr_data | output | 8 | Data byte of the strobe |
| rf_rd_addr | output | 8 | Current register pointer, presented for reading |
| rf_rd_data | input | 8 | Register-file byte at rf_rd_addr |

## Verification
A multi-byte write can reach the boundary between the configuration and status areas. In that case the acknowledge decision for one byte and the move of the pointer into an area with a different grant happen on the same SCL falling edge. Directed writes starting at 0x24 provoke this with only the configuration area granted. Random transfers with random start registers, lengths, grants and device or group addressing provoke it again. Every acknowledge bit is compared with the bench's model of pointer, grant and lock state, and the register contents are then read back through the device address and compared byte by byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_DONE,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_DONE,
        ST_REG_ACK,
        ST_WR,
        ST_WR_DONE,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_RD_NEXT,
        ST_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        AREA_ADDR,
        AREA_CFG,
        AREA_STAT,
        AREA_NONE
    } area_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_q = scl_pipe[STAGES-1];
    assign sda_q = sda_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_q;
            sda_d <= sda_q;
        end
    end

    assign scl_rise = scl_q & ~scl_d;
    assign scl_fall = ~scl_q & scl_d;
    assign start_p  = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_p   = scl_q & scl_d & ~sda_d & sda_q;

    // R1: bus events are mutually exclusive in any cycle
    a_r1_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start_p, stop_p}));

endmodule

// File: rtl/i2c_tgt_addr_bank.sv
module i2c_tgt_addr_bank #(
    parameter logic [6:0] INIT_ADDR = 7'h0D
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_dev,
    input  logic       wr_grp,
    input  logic       wr_lock,
    input  logic [6:0] wdata,
    input  logic [6:0] rx_addr,
    input  logic       rx_rd,
    output logic [6:0] dev_addr,
    output logic [6:0] grp_addr,
    output logic       lock,
    output logic       cfg_valid,
    output logic       hit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_addr <= 7'h00;
            grp_addr <= 7'h00;
            lock     <= 1'b0;
        end else begin
            if (wr_dev)  dev_addr <= wdata;
            if (wr_grp)  grp_addr <= wdata;
            if (wr_lock) lock     <= wdata[0];
        end
    end

    assign cfg_valid = (dev_addr != INIT_ADDR) && (grp_addr != INIT_ADDR) &&
                       (dev_addr != 7'h00) && (grp_addr != 7'h00) &&
                       (dev_addr != grp_addr);

    always_comb begin
        if (!lock)
            hit = (rx_addr == INIT_ADDR);
        else
            hit = (rx_addr == dev_addr) || ((rx_addr == grp_addr) && !rx_rd);
    end

    // R9: the lock can only be taken while the addresses are valid
    a_r9_lock_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(cfg_valid));

    // R8: the address registers hold still while locked
    a_r8_frozen_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && $past(lock)) |-> ($stable(dev_addr) && $stable(grp_addr)));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] INIT_ADDR   = 7'h0D,
    parameter logic [7:0] CFG_FIRST   = 8'h03,
    parameter logic [7:0] CFG_LAST    = 8'h25,
    parameter logic [7:0] STAT_FIRST  = 8'h26,
    parameter logic [7:0] STAT_LAST   = 8'h37,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] area_grant,
    output logic       rf_wr_en,
    output logic [7:0] rf_wr_addr,
    output logic [7:0] rf_wr_data,
    output logic [7:0] rf_rd_addr,
    input  logic [7:0] rf_rd_data
);

    localparam int         BYTE_W   = 8;
    localparam int         CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [7:0] REG_DEV  = 8'h00;
    localparam logic [7:0] REG_GRP  = 8'h01;
    localparam logic [7:0] REG_LOCK = 8'h02;

    tgt_state_e        state, state_n;
    logic              sda_q, scl_rise, scl_fall, start_p, stop_p;
    logic [CNT_W-1:0]  bitcnt;
    logic [7:0]        rx_sh, tx_sh, ptr, rd_byte;
    logic              ptr_valid, rd_mode;
    logic [6:0]        dev_addr, grp_addr;
    logic              lock, cfg_valid, hit;
    logic              last_bit, wr_ok, wr_fire;
    area_e             ptr_area;

    function automatic area_e area_of(input logic [7:0] a);
        if (a < CFG_FIRST)                          return AREA_ADDR;
        else if (a <= CFG_LAST)                     return AREA_CFG;
        else if ((a >= STAT_FIRST) && (a <= STAT_LAST)) return AREA_STAT;
        else                                        return AREA_NONE;
    endfunction

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_q    (sda_q),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    assign ptr_area = area_of(ptr);
    assign last_bit = (bitcnt == LAST_BIT);
    assign wr_fire  = (state == ST_WR_DONE) && scl_fall && wr_ok;

    i2c_tgt_addr_bank #(.INIT_ADDR(INIT_ADDR)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_dev    (wr_fire && (ptr == REG_DEV)),
        .wr_grp    (wr_fire && (ptr == REG_GRP)),
        .wr_lock   (wr_fire && (ptr == REG_LOCK)),
        .wdata     (rx_sh[6:0]),
        .rx_addr   (rx_sh[7:1]),
        .rx_rd     (rx_sh[0]),
        .dev_addr  (dev_addr),
        .grp_addr  (grp_addr),
        .lock      (lock),
        .cfg_valid (cfg_valid),
        .hit       (hit)
    );

    // Acceptance of the byte held in rx_sh at the pointer
    always_comb begin
        unique case (ptr_area)
            AREA_ADDR: begin
                if (ptr == REG_LOCK) wr_ok = !(rx_sh[0] && !cfg_valid);
                else                 wr_ok = !lock;
            end
            AREA_CFG:  wr_ok = area_grant[0];
            AREA_STAT: wr_ok = area_grant[1];
            default:   wr_ok = 1'b0;
        endcase
    end

    // Byte returned at the pointer
    always_comb begin
        unique case (ptr_area)
            AREA_ADDR: begin
                if (ptr == REG_DEV)      rd_byte = {1'b0, dev_addr};
                else if (ptr == REG_GRP) rd_byte = {1'b0, grp_addr};
                else                     rd_byte = {7'd0, lock};
            end
            AREA_CFG, AREA_STAT: rd_byte = rf_rd_data;
            default:             rd_byte = 8'h00;
        endcase
    end

    assign rf_rd_addr = ptr;

    // Next-state logic
    always_comb begin
        state_n = state;
        if (stop_p) begin
            state_n = ST_IDLE;
        end else if (start_p) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: state_n = state;
                ST_ADDR:      if (scl_rise && last_bit) state_n = ST_ADDR_DONE;
                ST_ADDR_DONE: if (scl_fall) state_n = hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (scl_fall) state_n = rd_mode ? ST_RD : ST_REG;
                ST_REG:       if (scl_rise && last_bit) state_n = ST_REG_DONE;
                ST_REG_DONE:  if (scl_fall) state_n = ST_REG_ACK;
                ST_REG_ACK:   if (scl_fall) state_n = ST_WR;
                ST_WR:        if (scl_rise && last_bit) state_n = ST_WR_DONE;
                ST_WR_DONE:   if (scl_fall) state_n = wr_ok ? ST_WR_ACK : ST_SKIP;
                ST_WR_ACK:    if (scl_fall) state_n = ST_WR;
                ST_RD:        if (scl_fall && last_bit) state_n = ST_RD_ACK;
                ST_RD_ACK:    if (scl_rise) state_n = sda_q ? ST_SKIP : ST_RD_NEXT;
                ST_RD_NEXT:   if (scl_fall) state_n = ST_RD;
                default:      state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt     <= '0;
            rx_sh      <= 8'h00;
            tx_sh      <= 8'h00;
            ptr        <= 8'h00;
            ptr_valid  <= 1'b0;
            rd_mode    <= 1'b0;
            sda_oe     <= 1'b0;
            rf_wr_en   <= 1'b0;
            rf_wr_addr <= 8'h00;
            rf_wr_data <= 8'h00;
        end else begin
            rf_wr_en <= 1'b0;
            if (stop_p) begin
                sda_oe    <= 1'b0;
                ptr_valid <= 1'b0;
            end else if (start_p) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_REG, ST_WR: begin
                        if (scl_rise) begin
                            rx_sh  <= {rx_sh[6:0], sda_q};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_ADDR_DONE: begin
                        if (scl_fall) begin
                            rd_mode <= rx_sh[0];
                            if (hit) begin
                                sda_oe <= 1'b1;
                                if (rx_sh[0] && !ptr_valid) ptr <= STAT_FIRST;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rd_mode) begin
                                tx_sh  <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_REG_DONE: begin
                        if (scl_fall) begin
                            ptr       <= rx_sh;
                            ptr_valid <= 1'b1;
                            sda_oe    <= 1'b1;
                        end
                    end
                    ST_REG_ACK, ST_WR_ACK: begin
                        if (scl_fall) sda_oe <= 1'b0;
                    end
                    ST_WR_DONE: begin
                        if (wr_fire) begin
                            sda_oe <= 1'b1;
                            ptr    <= ptr + 8'd1;
                            if ((ptr_area == AREA_CFG) || (ptr_area == AREA_STAT)) begin
                                rf_wr_en   <= 1'b1;
                                rf_wr_addr <= ptr;
                                rf_wr_data <= rx_sh;
                            end
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (last_bit) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 8'd1;
                                bitcnt <= '0;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_NEXT: begin
                        if (scl_fall) begin
                            tx_sh  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            bitcnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: SDA is released after STOP
    a_r1_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !sda_oe);

    // R6: a read with no pointer byte starts in the status area
    a_r6_status_default: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_DONE && scl_fall && hit && rx_sh[0] && !ptr_valid)
        |=> (ptr == STAT_FIRST));

    // R10: every register-file write goes out together with its acknowledge
    a_r10_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> sda_oe);

endmodule

// File: tb/i2c_reg_target_test.sv
`timescale 1ns/1ps
module i2c_reg_target_test;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       sda_bus;
    logic [1:0] area_grant = 2'b00;
    logic       rf_wr_en;
    logic [7:0] rf_wr_addr, rf_wr_data, rf_rd_addr, rf_rd_data;

    logic [7:0] rf_mem [0:255];
    logic [7:0] m_mem  [0:255];
    logic [6:0] m_dev, m_grp;
    logic       m_lock;
    logic [7:0] wbuf [0:7];
    int         n_chk = 0;
    int         n_bad = 0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus    = sda_m & ~sda_oe;
    assign rf_rd_data = rf_mem[rf_rd_addr];

    always @(posedge clk) if (rf_wr_en) rf_mem[rf_wr_addr] <= rf_wr_data;

    i2c_reg_target uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe     (sda_oe),
        .area_grant (area_grant),
        .rf_wr_en   (rf_wr_en),
        .rf_wr_addr (rf_wr_addr),
        .rf_wr_data (rf_wr_data),
        .rf_rd_addr (rf_rd_addr),
        .rf_rd_data (rf_rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---- reference model ----
    function automatic logic m_valid();
        return (m_dev != 7'h0D) && (m_grp != 7'h0D) && (m_dev != 7'h00) &&
               (m_grp != 7'h00) && (m_dev != m_grp);
    endfunction

    function automatic logic exp_addr_ack(input logic [6:0] a, input logic rd);
        if (!m_lock) return a == 7'h0D;
        return (a == m_dev) || ((a == m_grp) && !rd);
    endfunction

    function automatic logic exp_wr_ok(input logic [7:0] p, input logic [7:0] d);
        if (p <= 8'h01) return !m_lock;
        if (p == 8'h02) return !(d[0] && !m_valid());
        if (p <= 8'h25) return area_grant[0];
        if (p <= 8'h37) return area_grant[1];
        return 1'b0;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] p);
        if (p == 8'h00) return {1'b0, m_dev};
        if (p == 8'h01) return {1'b0, m_grp};
        if (p == 8'h02) return {7'd0, m_lock};
        if (p <= 8'h37) return m_mem[p];
        return 8'h00;
    endfunction

    task automatic model_write(input logic [7:0] p, input logic [7:0] d);
        if (p == 8'h00)      m_dev  = d[6:0];
        else if (p == 8'h01) m_grp  = d[6:0];
        else if (p == 8'h02) m_lock = d[0];
        else                 m_mem[p] = d;
    endtask

    // ---- bus controller ----
    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic more);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!more);
    endtask

    task automatic do_write(input string req, input logic [6:0] a, input logic [7:0] r, input int n);
        logic ack;
        logic [7:0] p;
        bus_start();
        put_byte({a, 1'b0}, ack);
        chk(req, ack, exp_addr_ack(a, 1'b0));
        if (ack) begin
            put_byte(r, ack);
            chk("R5", ack, 1'b1);
            p = r;
            for (int k = 0; k < n; k++) begin
                logic ok;
                ok = exp_wr_ok(p, wbuf[k]);
                put_byte(wbuf[k], ack);
                chk(req, ack, ok);
                if (!ok) break;
                model_write(p, wbuf[k]);
                p = p + 8'd1;
            end
        end
        bus_stop();
        chk("R1", sda_oe, 1'b0);
    endtask

    task automatic do_read(input string req, input logic [6:0] a, input logic use_ptr,
                           input logic [7:0] r, input int n);
        logic ack;
        logic [7:0] p, v;
        bus_start();
        ack = 1'b1;
        if (use_ptr) begin
            put_byte({a, 1'b0}, ack);
            chk(req, ack, exp_addr_ack(a, 1'b0));
            if (ack) begin
                put_byte(r, ack);
                chk("R5", ack, 1'b1);
                bus_start();
            end
        end
        if (ack) begin
            put_byte({a, 1'b1}, ack);
            chk(req, ack, exp_addr_ack(a, 1'b1));
            if (ack) begin
                p = use_ptr ? r : 8'h26;
                for (int k = 0; k < n; k++) begin
                    get_byte(v, k < n - 1);
                    chk(req, v, exp_rd(p));
                    p = p + 8'd1;
                end
                chk("R7", sda_oe, 1'b0);
            end
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) begin
            rf_mem[i] = 8'(i * 7) ^ 8'h5C;
            m_mem[i]  = 8'(i * 7) ^ 8'h5C;
        end
        m_dev = 7'h00; m_grp = 7'h00; m_lock = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1", sda_oe, 1'b0);
        chk("R12", rf_wr_en, 1'b0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2: wrong address refused before lock
        wbuf[0] = 8'h11;
        do_write("R2", 7'h20, 8'h05, 1);
        // R12 / R11: reset values of the address bank
        do_read("R12", 7'h0D, 1'b1, 8'h00, 3);
        // R9: lock refused with an invalid device address
        wbuf[0] = 8'h0D;
        do_write("R8", 7'h0D, 8'h00, 1);
        wbuf[0] = 8'h01;
        do_write("R9", 7'h0D, 8'h02, 1);
        do_read("R9", 7'h0D, 1'b1, 8'h02, 1);
        // R8 / R9: program and lock valid addresses in one transfer
        wbuf[0] = 8'h21; wbuf[1] = 8'h33; wbuf[2] = 8'h01;
        do_write("R9", 7'h0D, 8'h00, 3);
        // R3: start-up address no longer answered, device address is
        wbuf[0] = 8'h44;
        do_write("R3", 7'h0D, 8'h05, 1);
        // R6: read with no pointer begins at 0x26
        do_read("R6", 7'h21, 1'b0, 8'h00, 3);
        // R4: group read refused, group write performed
        do_read("R4", 7'h33, 1'b0, 8'h00, 1);
        area_grant = 2'b01;
        wbuf[0] = 8'h5A;
        do_write("R4", 7'h33, 8'h05, 1);
        do_read("R4", 7'h21, 1'b1, 8'h05, 1);
        // R10: config write refused without grant, state unchanged
        area_grant = 2'b00;
        wbuf[0] = 8'hC3;
        do_write("R10", 7'h21, 8'h06, 1);
        do_read("R10", 7'h21, 1'b1, 8'h06, 1);
        // R10: status area grant
        area_grant = 2'b10;
        wbuf[0] = 8'h9E;
        do_write("R10", 7'h21, 8'h30, 1);
        area_grant = 2'b00;
        wbuf[0] = 8'h7B;
        do_write("R10", 7'h21, 8'h31, 1);
        do_read("R10", 7'h21, 1'b1, 8'h30, 2);
        // R5 / R10: auto-increment across the area boundary
        area_grant = 2'b01;
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
        do_write("R5", 7'h21, 8'h24, 3);
        do_read("R5", 7'h21, 1'b1, 8'h24, 3);
        // R11: unimplemented registers
        area_grant = 2'b11;
        wbuf[0] = 8'hFF;
        do_write("R11", 7'h21, 8'h38, 1);
        do_read("R11", 7'h21, 1'b1, 8'h36, 4);
        // R8: address registers refuse writes while locked
        wbuf[0] = 8'h40;
        do_write("R8", 7'h21, 8'h00, 1);
        do_read("R8", 7'h21, 1'b1, 8'h00, 3);

        // random transfers
        for (int it = 0; it < 20; it++) begin
            logic [7:0] r;
            int n;
            logic [6:0] tgt;
            area_grant = 2'($urandom % 4);
            r = 8'h03 + 8'($urandom % 56);
            n = 1 + int'($urandom % 4);
            tgt = ($urandom % 2 == 0) ? 7'h21 : 7'h33;
            for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
            do_write("R10", tgt, r, n);
            do_read("R7", 7'h21, 1'b1, r, n + 1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule